// File: doc/BRIEF.md
# Channel command stream decoder

This block sits between a command fetch path and a set of engines. It takes a stream of 32-bit command words and turns them into method writes. Each write carries a class ID, a 12-bit method offset and a 32-bit data word. Some words are headers and some are payloads. A header selects one of five submission modes:

- set-class, which changes the current target class and may open a short masked burst;
- counted incrementing burst;
- counted non-incrementing burst;
- masked burst with a 16-bit mask;
- immediate write with a 12-bit data value.

The block holds the current class in a register. Every write it issues goes out with a one-hot engine select, which is decided by comparing that class against a parameter table.

Both the input and the output use valid/ready handshakes. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. A write is handed on when `out_valid` and `out_ready` are both high. The output is a single register stage, and `in_ready` is high whenever that stage is empty or is being emptied in the same cycle. While the stage holds a write that has not been taken, input is stalled and every piece of decoder state is frozen. This applies to header words as well as payload words. A header code the block does not recognise produces a one-cycle error pulse and nothing else.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, `out_valid` and `bad_mode` are 0, `in_ready` is 1, and the current class is 0. A burst sent before any set-class header therefore carries class 0 and an all-zero engine select.
- R2: A header word is laid out as mode in bits 31:28, method offset in bits 27:16 and value in bits 15:0. The mode codes are 0 for set-class, 1 for incrementing, 2 for non-incrementing, 3 for masked and 4 for immediate.
- R3: A set-class header does three things. It sets the class to value bits 15:6 and the base offset to the method offset. It also loads value bits 5:0 as a mask. One payload word then follows for each set mask bit, lowest bit first, and each is written to base plus that bit's index, taken modulo 4096.
- R4: A masked header loads the full 16-bit value as the mask and the method offset as the base. Payloads then follow exactly as in R3. A zero mask means no payload follows.
- R5: An incrementing header loads the value as a payload count N and the method offset as the start. The next N words are written to start, start+1, and so on, modulo 4096. N=0 means no payload follows.
- R6: A non-incrementing header behaves like R5, except that all N payloads go to the same offset.
- R7: An immediate header makes exactly one write, to its method offset, with data equal to value bits 11:0 zero-extended to 32 bits. No payload follows it.
- R8: While a mask or a count is pending, every word is a payload and is never decoded as a header, whatever its top bits hold. A pending mask is served before a pending count.
- R9: A header with mode code 5 to 15 raises `bad_mode` for exactly the cycle after the word is accepted. It makes no write and leaves the class, mask, count and offset unchanged.
- R10: Each write carries the current class. `out_port` has bit i set only when that class equals entry i of `PORT_CLASSES`, and it is all-zero for a class with no entry.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all output fields hold. No write is lost or repeated.
- R12: A word that makes a write shows it on `out_valid` the cycle after the word is accepted. Set-class, burst and masked headers make no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_word | input | 32 | Command word, either a header or a payload |
| in_ready | output | 1 | Decoder accepts the word this cycle |
| out_valid | output | 1 | Method write present |
| out_ready | input | 1 | Downstream takes the write this cycle |
| out_class | output | 10 | Class ID of the write |
| out_offset | output | 12 | Method offset of the write |
| out_data | output | 32 | Data word of the write |
| out_port | output | NUM_PORTS | One-hot engine select, or zero when the class has no engine |
| bad_mode | output | 1 | One-cycle pulse for a header with an unknown mode code |

## Verification
The bench targets the following corner cases:

- It sweeps every 6-bit set-class mask, a range of 16-bit masks, and a range of burst counts starting from zero. A decoder that scans the mask from the wrong end, skips a bit, or miscounts a burst by one writes the wrong offset or the wrong number of words.
- Bases near 0xFFF check that the offset wraps modulo 4096 and does not carry into the class.
- Payload words whose top bits look like immediate or unknown headers catch a decoder that re-decodes words while a burst is still pending. Such a decoder would emit stray immediate writes or error pulses.
- Random back-pressure checks that a stalled write holds steady and that no header is taken during a stall. A decoder that lets state advance during a stall would drop or duplicate writes.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W    = 32;
  localparam int MODE_W    = 4;
  localparam int OFF_W     = 12;
  localparam int VAL_W     = 16;
  localparam int CLS_W     = 10;
  localparam int SC_MASK_W = 6;
  localparam int IMM_W     = 12;
  localparam int OFF_LSB   = VAL_W;
  localparam int MODE_LSB  = VAL_W + OFF_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_SETCLS = 4'd0,
    MODE_INCR   = 4'd1,
    MODE_FIXED  = 4'd2,
    MODE_MASKED = 4'd3,
    MODE_IMM    = 4'd4
  } hdr_mode_e;
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
  import cmd_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [OFF_W-1:0]  off,
  output logic [VAL_W-1:0]  val,
  output logic              is_setcls,
  output logic              is_incr,
  output logic              is_fixed,
  output logic              is_masked,
  output logic              is_imm,
  output logic              known
);
  hdr_mode_e mode;

  assign mode = hdr_mode_e'(word[MODE_LSB +: MODE_W]);
  assign off  = word[OFF_LSB +: OFF_W];
  assign val  = word[0 +: VAL_W];

  always_comb begin
    is_setcls = 1'b0;
    is_incr   = 1'b0;
    is_fixed  = 1'b0;
    is_masked = 1'b0;
    is_imm    = 1'b0;
    case (mode)
      MODE_SETCLS: is_setcls = 1'b1;
      MODE_INCR:   is_incr   = 1'b1;
      MODE_FIXED:  is_fixed  = 1'b1;
      MODE_MASKED: is_masked = 1'b1;
      MODE_IMM:    is_imm    = 1'b1;
      default:     ;
    endcase
  end

  assign known = is_setcls | is_incr | is_fixed | is_masked | is_imm;
endmodule

// File: rtl/lowbit_find.sv
module lowbit_find #(
  parameter int W = 16,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
)(
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     hot,
  output logic [IDX_W-1:0] idx
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign hot = vec & (~vec + W'(1));
endmodule

// File: rtl/port_route.sv
module port_route #(
  parameter int NUM_PORTS = 3,
  parameter int CLS_W = 10,
  parameter logic [NUM_PORTS*CLS_W-1:0] PORT_CLASSES = '0
)(
  input  logic [CLS_W-1:0]     cls,
  output logic [NUM_PORTS-1:0] sel
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign sel[p] = (cls == PORT_CLASSES[p*CLS_W +: CLS_W]);
  end
endmodule

// File: rtl/out_stage.sv
module out_stage
  import cmd_dec_pkg::*;
#(
  parameter int NUM_PORTS = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 load,
  input  logic [CLS_W-1:0]     cls_in,
  input  logic [OFF_W-1:0]     off_in,
  input  logic [WORD_W-1:0]    data_in,
  input  logic [NUM_PORTS-1:0] port_in,
  output logic                 valid,
  output logic [CLS_W-1:0]     cls_out,
  output logic [OFF_W-1:0]     off_out,
  output logic [WORD_W-1:0]    data_out,
  output logic [NUM_PORTS-1:0] port_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      cls_out  <= '0;
      off_out  <= '0;
      data_out <= '0;
      port_out <= '0;
    end else if (advance) begin
      valid <= load;
      if (load) begin
        cls_out  <= cls_in;
        off_out  <= off_in;
        data_out <= data_in;
        port_out <= port_in;
      end
    end
  end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter logic [NUM_PORTS*CLS_W-1:0] PORT_CLASSES = {10'h0C0, 10'h071, 10'h005}
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CLS_W-1:0]     out_class,
  output logic [OFF_W-1:0]     out_offset,
  output logic [WORD_W-1:0]    out_data,
  output logic [NUM_PORTS-1:0] out_port,
  output logic                 bad_mode
);
  localparam int MASK_W  = VAL_W;
  localparam int COUNT_W = VAL_W;
  localparam int IDX_W   = $clog2(MASK_W);

  logic [OFF_W-1:0]     h_off;
  logic [VAL_W-1:0]     h_val;
  logic                 h_setcls, h_incr, h_fixed, h_masked, h_imm, h_known;
  logic [MASK_W-1:0]    mask_q;
  logic [COUNT_W-1:0]   cnt_q;
  logic [OFF_W-1:0]     base_q;
  logic                 incr_q;
  logic [CLS_W-1:0]     class_q;
  logic                 bad_q;
  logic [MASK_W-1:0]    low_hot;
  logic [IDX_W-1:0]     low_idx;
  logic [NUM_PORTS-1:0] route_sel;
  logic                 pay_mask, pay_cnt, fire;
  logic                 wr_en, bad_word;
  logic [OFF_W-1:0]     wr_off;
  logic [WORD_W-1:0]    wr_data;

  hdr_decode u_hdr (
    .word      (in_word),
    .off       (h_off),
    .val       (h_val),
    .is_setcls (h_setcls),
    .is_incr   (h_incr),
    .is_fixed  (h_fixed),
    .is_masked (h_masked),
    .is_imm    (h_imm),
    .known     (h_known)
  );

  lowbit_find #(.W(MASK_W)) u_low (
    .vec (mask_q),
    .hot (low_hot),
    .idx (low_idx)
  );

  port_route #(
    .NUM_PORTS    (NUM_PORTS),
    .CLS_W        (CLS_W),
    .PORT_CLASSES (PORT_CLASSES)
  ) u_route (
    .cls (class_q),
    .sel (route_sel)
  );

  assign pay_mask = |mask_q;
  assign pay_cnt  = |cnt_q;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // what the accepted word produces this cycle
  always_comb begin
    wr_en    = 1'b0;
    wr_off   = base_q;
    wr_data  = in_word;
    bad_word = 1'b0;
    if (pay_mask) begin
      wr_en  = 1'b1;
      wr_off = base_q + OFF_W'(low_idx);
    end else if (pay_cnt) begin
      wr_en = 1'b1;
    end else begin
      wr_off   = h_off;
      bad_word = !h_known;
      if (h_imm) begin
        wr_en   = 1'b1;
        wr_data = WORD_W'(h_val[IMM_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      incr_q  <= 1'b0;
      class_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= fire && bad_word;
      if (fire) begin
        if (pay_mask) begin
          mask_q <= mask_q & ~low_hot;
        end else if (pay_cnt) begin
          cnt_q <= cnt_q - COUNT_W'(1);
          if (incr_q) base_q <= base_q + OFF_W'(1);
        end else begin
          if (h_setcls) begin
            mask_q  <= MASK_W'(h_val[SC_MASK_W-1:0]);
            base_q  <= h_off;
            class_q <= h_val[VAL_W-1:SC_MASK_W];
          end
          if (h_incr || h_fixed) begin
            cnt_q  <= h_val;
            base_q <= h_off;
            incr_q <= h_incr;
          end
          if (h_masked) begin
            mask_q <= h_val;
            base_q <= h_off;
          end
        end
      end
    end
  end

  assign bad_mode = bad_q;

  out_stage #(.NUM_PORTS(NUM_PORTS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (in_ready),
    .load     (fire && wr_en),
    .cls_in   (class_q),
    .off_in   (wr_off),
    .data_in  (wr_data),
    .port_in  (route_sel),
    .valid    (out_valid),
    .cls_out  (out_class),
    .off_out  (out_offset),
    .data_out (out_data),
    .port_out (out_port)
  );
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
  parameter int NUM_PORTS = 3
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [9:0]           out_class,
  input logic [11:0]          out_offset,
  input logic [31:0]          out_data,
  input logic [NUM_PORTS-1:0] out_port,
  input logic                 bad_mode
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_offset)
      && $stable(out_class) && $stable(out_port));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_port));

  // R12
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R9
  bad_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> $past(in_valid && in_ready));

  // R9
  bad_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> !out_valid);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_class  (out_class),
  .out_offset (out_offset),
  .out_data   (out_data),
  .out_port   (out_port),
  .bad_mode   (bad_mode)
);

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
  localparam int NP = 3;
  localparam logic [29:0] PCL = {10'h0C0, 10'h071, 10'h005};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_word = '0;
  logic          in_ready;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [9:0]    out_class;
  logic [11:0]   out_offset;
  logic [31:0]   out_data;
  logic [NP-1:0] out_port;
  logic          bad_mode;

  cmd_stream_decoder i_cmd_stream_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_offset(out_offset), .out_data(out_data), .out_port(out_port), .bad_mode(bad_mode)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [9:0]  e_cls [0:511];
  logic [11:0] e_off [0:511];
  logic [31:0] e_dat [0:511];
  int e_n = 0;
  logic [9:0]    o_cls [0:511];
  logic [11:0]   o_off [0:511];
  logic [31:0]   o_dat [0:511];
  logic [NP-1:0] o_prt [0:511];
  int o_n = 0;
  int bad_cnt = 0;

  bit stall_prev = 0;
  logic [53:0]   hold_f;
  logic [NP-1:0] hold_p;
  logic [9:0]    cur_cls = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int m, input int off, input int v);
    return {m[3:0], off[11:0], v[15:0]};
  endfunction

  function automatic logic [NP-1:0] port_of(input logic [9:0] c);
    logic [NP-1:0] s = '0;
    for (int p = 0; p < NP; p++) if (PCL[p*10 +: 10] == c) s[p] = 1'b1;
    return s;
  endfunction

  task automatic push(input logic [9:0] c, input int off, input logic [31:0] d);
    e_cls[e_n] = c;
    e_off[e_n] = off[11:0];
    e_dat[e_n] = d;
    e_n++;
  endtask

  // ready driver and write monitor
  always @(negedge clk) begin
    if (rdy_mode == 0) out_ready = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[2];
    end
    #1;
    if (rst_n) begin
      if (stall_prev)  // R11 held output
        chk(out_valid && {out_class, out_offset, out_data} == hold_f && out_port == hold_p,
            "R11 stalled write held", {out_class, out_offset, out_data}, hold_f);
      stall_prev = out_valid && !out_ready;
      if (stall_prev) begin
        hold_f = {out_class, out_offset, out_data};
        hold_p = out_port;
        chk(!in_ready, "R11 input blocked during stall", 64'(in_ready), 64'd0);
      end
      if (out_valid && out_ready) begin
        o_cls[o_n] = out_class;
        o_off[o_n] = out_offset;
        o_dat[o_n] = out_data;
        o_prt[o_n] = out_port;
        o_n++;
      end
      if (bad_mode) bad_cnt++;
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic settle(input string req, input int exp_bad);
    int n;
    repeat (30) @(negedge clk);
    chk(o_n == e_n, {req, " write count"}, 64'(o_n), 64'(e_n));
    n = (o_n < e_n) ? o_n : e_n;
    for (int i = 0; i < n; i++) begin
      chk({o_cls[i], o_off[i], o_dat[i]} == {e_cls[i], e_off[i], e_dat[i]}, req,
          {o_cls[i], o_off[i], o_dat[i]}, {e_cls[i], e_off[i], e_dat[i]});
      chk(o_prt[i] == port_of(e_cls[i]), "R10 engine select", 64'(o_prt[i]), 64'(port_of(e_cls[i])));
    end
    chk(bad_cnt == exp_bad, "R9 error pulse count", 64'(bad_cnt), 64'(exp_bad));
    o_n = 0;
    e_n = 0;
    bad_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] c;
    int b;
    logic [31:0] d;
    logic [15:0] mv;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(!out_valid && !bad_mode && in_ready, "R1 reset outputs",
        {61'd0, out_valid, bad_mode, in_ready}, 64'd1);
    @(negedge clk) rst_n = 1'b1;

    // R1: class 0 before any set-class, R5 single-word burst
    send(hdr(1, 12'h0AB, 1));
    send(32'h1111_2222);
    push(10'h000, 12'h0AB, 32'h1111_2222);
    settle("R1 class 0 after reset", 0);

    // R12 latency of an immediate, R7 data truncation
    send(hdr(4, 12'h345, 16'hF678));
    push(10'h000, 12'h345, 32'h0000_0678);
    @(negedge clk);
    #3;
    chk(out_valid && out_offset == 12'h345 && out_data == 32'h678, "R12 write one cycle after accept",
        {out_valid, out_offset, out_data}, {1'b1, 12'h345, 32'h678});
    send(hdr(1, 12'h010, 0));
    @(negedge clk);
    #3;
    chk(!out_valid, "R12 burst header makes no write", 64'(out_valid), 64'd0);
    settle("R7 immediate", 0);

    // R3 sweep of every set-class mask, lowest bit first, with offset wrap
    for (int m = 1; m < 64; m++) begin
      rdy_mode = (m >= 32) ? 1 : 0;
      c = (m % 4 == 0) ? 10'h005 : (m % 4 == 1) ? 10'h071 : (m % 4 == 2) ? 10'h0C0 : 10'h2A3;
      b = (m == 63) ? 12'hFFC : (m * 37) % 4096;
      send(hdr(0, b, {c, 6'(m)}));
      for (int i = 0; i < 6; i++) begin
        if (m[i]) begin
          d = {8'(m), 8'(i), 16'hBEEF ^ 16'(m * i)};
          push(c, (b + i) % 4096, d);
          send(d);
        end
      end
    end
    settle("R3 set-class mask sweep", 0);
    cur_cls = 10'h2A3;

    // R4 masked mode, 16-bit masks including zero
    send(hdr(0, 0, {10'h071, 6'd0}));
    cur_cls = 10'h071;
    for (int k = 0; k < 4; k++) begin
      mv = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h8001 : (k == 2) ? 16'h0000 : 16'hA5A5;
      b  = (k == 0) ? 12'h100 : (k == 1) ? 12'hFFA : (k == 2) ? 12'h123 : 12'h7F0;
      send(hdr(3, b, mv));
      for (int i = 0; i < 16; i++) begin
        if (mv[i]) begin
          d = {16'hA000 + 16'(k), 16'(i)};
          push(cur_cls, (b + i) % 4096, d);
          send(d);
        end
      end
    end
    settle("R4 masked bursts", 0);

    // R5 incrementing bursts, counts 0..5, wrap at 4095
    for (int k = 0; k < 6; k++) begin
      b = (k == 5) ? 12'hFFD : k * 100;
      send(hdr(1, b, k));
      for (int j = 0; j < k; j++) begin
        d = 32'hC0DE_0000 | (k << 8) | j;
        push(cur_cls, (b + j) % 4096, d);
        send(d);
      end
    end
    settle("R5 incrementing bursts", 0);

    // R6 non-incrementing bursts
    for (int k = 0; k < 6; k++) begin
      b = 12'h200 + k;
      send(hdr(2, b, k));
      for (int j = 0; j < k; j++) begin
        d = 32'hF1ED_0000 | (k << 8) | j;
        push(cur_cls, b, d);
        send(d);
      end
    end
    settle("R6 fixed-offset bursts", 0);

    // R7 immediates: only low 12 bits of the value
    for (int k = 0; k < 4; k++) begin
      mv = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h0ABC : 16'h1234;
      b  = 12'hE00 + k * 3;
      send(hdr(4, b, mv));
      push(cur_cls, b, {20'd0, mv[11:0]});
    end
    settle("R7 immediate values", 0);

    // R8 payloads that look like headers are data
    rdy_mode = 0;
    send(hdr(0, 12'h040, {10'h0C0, 6'b000011}));
    cur_cls = 10'h0C0;
    send(hdr(4, 12'h777, 16'h0555));
    push(cur_cls, 12'h040, hdr(4, 12'h777, 16'h0555));
    send(hdr(7, 12'h001, 16'h0001));
    push(cur_cls, 12'h041, hdr(7, 12'h001, 16'h0001));
    send(hdr(1, 12'h300, 2));
    send(hdr(0, 12'h005, 16'h003F));
    push(cur_cls, 12'h300, hdr(0, 12'h005, 16'h003F));
    send(32'hF000_0000);
    push(cur_cls, 12'h301, 32'hF000_0000);
    settle("R8 payload never decoded", 0);

    // R9 unknown codes 5..15: pulse each, no write, state kept
    rdy_mode = 1;
    for (int m = 5; m < 16; m++) send(hdr(m, 12'h055, 16'hFFFF));
    send(hdr(2, 12'h010, 1));
    send(32'h9999_0001);
    push(cur_cls, 12'h010, 32'h9999_0001);
    settle("R9 unknown modes keep state", 11);

    // R10 class with no engine gives a zero select
    send(hdr(0, 12'h020, {10'h3FF, 6'b000001}));
    send(32'h0DEF_0000);
    push(10'h3FF, 12'h020, 32'h0DEF_0000);
    settle("R10 unrouted class", 0);

    // R2 field positions: offset and value fields exercised at their extremes
    rdy_mode = 0;
    send(hdr(4, 12'hFFF, 16'h0FFF));
    push(10'h3FF, 12'hFFF, 32'h0000_0FFF);
    settle("R2 header fields", 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule